// File: doc/BRIEF.md
# Command Retry and Recovery Sequencer

This block runs one command at a time on behalf of a requester for a disk-style controller. After a start request it hands the command to an execution port and waits for a completion or for a watchdog to expire. When the executor completes, the block looks at the upper nibble of the returned 8-bit error code, the action class. That class decides between three outcomes: finish with success, issue the same command again, or request a controller reset and then issue the command again.

The number of attempts is capped. The wait for a command and the wait for a reset acknowledge each have their own watchdog, and both limits are counted in clock cycles. A single-cycle done pulse ends every command. It carries a final status code, the last error code seen and the number of attempts made. The meaning of individual error codes, the data path and DMA are handled elsewhere.

Top module: `retry_sequencer`

## Requirements
- R1: After reset, busy_o, issue_o, rst_req_o and done_o are all low, and status_o, last_code_o and attempts_o are zero.
- R2: When start_i is high while busy_o is low, issue_o is high for exactly one cycle in the next cycle, and issue_cmd_o then equals the cmd_i value that was captured. A start_i while busy_o is high is ignored: it adds no issue and does not change the command.
- R3: A completion with code 0x00, or with any code whose upper nibble is 0x3 (recovered), ends the command with status 0 (success) and no further issue.
- R4: A completion whose upper nibble is 0x4 issues the same command again with no reset request, provided the attempt cap has not been reached.
- R5: A completion whose upper nibble is 0x6 raises rst_req_o and holds it until rst_ack_i is seen. The command is then issued again. issue_o is never high while rst_req_o is high.
- R6: A completion whose upper nibble is 0x1, 0x2 or 0x9 ends the command at once with status 1 (rejected) and no retry.
- R7: Every other code ends the command at once with status 3 (fatal) and no retry. This covers nonzero codes with upper nibble 0x0, the nibbles 0x5, 0x7, 0x8 and 0xA–0xF, and therefore all codes of 0xE0 and above.
- R8: At most MAX_TRIES issues are made per command. If the last allowed attempt ends with a retryable outcome (0x4, 0x6 or timeout), the command ends with status 2 (exhausted) and no reset is requested.
- R9: If no completion arrives within CMD_TMO_CYC cycles after an issue, the block records code 0xFF, requests a reset and retries, subject to R8.
- R10: If rst_ack_i does not arrive within RST_TMO_CYC cycles of raising rst_req_o, the command ends with status 4 (reset timeout).
- R11: done_o is a one-cycle pulse. With it, last_code_o holds the last code recorded and attempts_o holds the number of issues made for that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request from the requester |
| cmd_i | input | CMD_W | Command word captured at start |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| status_o | output | 3 | Final status: 0 ok, 1 rejected, 2 exhausted, 3 fatal, 4 reset timeout |
| last_code_o | output | 8 | Last recorded error code |
| attempts_o | output | AW | Issues made for the current command |
| issue_o | output | 1 | One-cycle issue strobe to the executor |
| issue_cmd_o | output | CMD_W | Command presented to the executor |
| cmpl_i | input | 1 | Executor completion strobe |
| err_code_i | input | 8 | Error code valid with cmpl_i |
| rst_req_o | output | 1 | Controller reset request, held until acknowledge |
| rst_ack_i | input | 1 | Controller reset acknowledge |

## Verification
The bench aims at the classification edges. It covers the recovered class 0x3 with a nonzero low nibble, nonzero codes in class 0x0, and codes in the 0xE0–0xFF range. A design that masked the code wrongly would retry these or report them as success. It drives retryable errors on the fourth attempt: a design that counted off by one would make a fifth issue or raise a reset it should not raise. It times out the executor and withholds the reset acknowledge, because a design with a broken watchdog hangs or reports the wrong status. It also pulses start while the block is busy, which a careless design would take as a new command.

// File: rtl/rr_pkg.sv
package rr_pkg;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_REJECT  = 3'd1,
    ST_EXHAUST = 3'd2,
    ST_FATAL   = 3'd3,
    ST_RST_TMO = 3'd4
  } rr_status_e;

  typedef enum logic [2:0] {
    ACT_PASS,
    ACT_REISSUE,
    ACT_RESET,
    ACT_REJECT,
    ACT_FATAL
  } rr_act_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_RESET
  } rr_state_e;

  localparam logic [7:0] TMO_CODE = 8'hFF;

  // Map a returned code (or a watchdog expiry) onto the action to take.
  function automatic rr_act_e rr_decide(input logic [7:0] code, input logic timed_out);
    rr_act_e act;
    if (timed_out) begin
      act = ACT_RESET;
    end else if (code == 8'h00) begin
      act = ACT_PASS;
    end else begin
      case (code[7:4])
        4'h3:             act = ACT_PASS;
        4'h4:             act = ACT_REISSUE;
        4'h6:             act = ACT_RESET;
        4'h1, 4'h2, 4'h9: act = ACT_REJECT;
        default:          act = ACT_FATAL;
      endcase
    end
    return act;
  endfunction

  // True while another issue is still allowed.
  function automatic logic rr_room(input int unsigned used, input int unsigned cap);
    return used < cap;
  endfunction

endpackage

// File: rtl/rr_classify.sv
module rr_classify
  import rr_pkg::*;
(
  input  logic [7:0] code_i,
  input  logic       timed_out_i,
  output rr_act_e    act_o
);
  assign act_o = rr_decide(code_i, timed_out_i);
endmodule

// File: rtl/rr_watchdog.sv
module rr_watchdog #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);

  generate
    if (LIMIT <= 1) begin : g_immediate
      assign expire_o = run_i;
    end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run_i)       cnt <= '0;
        else if (!expire_o)    cnt <= cnt + 1'b1;
      end
      assign expire_o = run_i && (cnt == CW'(LIMIT - 1));
    end
  endgenerate
endmodule

// File: rtl/retry_sequencer.sv
module retry_sequencer
  import rr_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int MAX_TRIES   = 4,
  parameter int CMD_TMO_CYC = 64,
  parameter int RST_TMO_CYC = 32,
  localparam int AW         = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       status_o,
  output logic [7:0]       last_code_o,
  output logic [AW-1:0]    attempts_o,
  output logic             issue_o,
  output logic [CMD_W-1:0] issue_cmd_o,
  input  logic             cmpl_i,
  input  logic [7:0]       err_code_i,
  output logic             rst_req_o,
  input  logic             rst_ack_i
);

  rr_state_e        state, state_nx;
  logic [CMD_W-1:0] cmd_q;
  logic [AW-1:0]    tries_q;
  logic [7:0]       code_q;
  logic             done_q;
  rr_status_e       stat_q;

  // Named internal events.
  logic       evt_accept;
  logic       evt_cmd_tmo;
  logic       evt_rst_tmo;
  logic       evt_result;
  logic       evt_finish;
  logic       can_retry;
  logic [7:0] seen_code;
  rr_act_e    act;
  rr_status_e fin_status;

  assign evt_accept = (state == S_IDLE) && start_i;
  assign can_retry  = rr_room(int'(tries_q), MAX_TRIES);
  assign evt_result = (state == S_WAIT) && (cmpl_i || evt_cmd_tmo);
  assign seen_code  = cmpl_i ? err_code_i : TMO_CODE;

  rr_watchdog #(.LIMIT(CMD_TMO_CYC)) u_cmd_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (state == S_WAIT),
    .expire_o(evt_cmd_tmo)
  );

  rr_watchdog #(.LIMIT(RST_TMO_CYC)) u_rst_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (state == S_RESET),
    .expire_o(evt_rst_tmo)
  );

  rr_classify u_cls (
    .code_i     (seen_code),
    .timed_out_i(!cmpl_i),
    .act_o      (act)
  );

  always_comb begin
    state_nx   = state;
    evt_finish = 1'b0;
    fin_status = ST_OK;
    unique case (state)
      S_IDLE:  if (start_i) state_nx = S_ISSUE;
      S_ISSUE: state_nx = S_WAIT;
      S_WAIT: begin
        if (evt_result) begin
          unique case (act)
            ACT_PASS: begin
              evt_finish = 1'b1;
              fin_status = ST_OK;
            end
            ACT_REISSUE: begin
              if (can_retry) state_nx = S_ISSUE;
              else begin
                evt_finish = 1'b1;
                fin_status = ST_EXHAUST;
              end
            end
            ACT_RESET: begin
              if (can_retry) state_nx = S_RESET;
              else begin
                evt_finish = 1'b1;
                fin_status = ST_EXHAUST;
              end
            end
            ACT_REJECT: begin
              evt_finish = 1'b1;
              fin_status = ST_REJECT;
            end
            default: begin
              evt_finish = 1'b1;
              fin_status = ST_FATAL;
            end
          endcase
        end
      end
      S_RESET: begin
        if (rst_ack_i) state_nx = S_ISSUE;
        else if (evt_rst_tmo) begin
          evt_finish = 1'b1;
          fin_status = ST_RST_TMO;
        end
      end
      default: state_nx = S_IDLE;
    endcase
    if (evt_finish) state_nx = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cmd_q   <= '0;
      tries_q <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
      stat_q  <= ST_OK;
    end else begin
      state  <= state_nx;
      done_q <= evt_finish;
      if (evt_accept) begin
        cmd_q   <= cmd_i;
        tries_q <= '0;
        code_q  <= '0;
      end
      if (state == S_ISSUE) tries_q <= tries_q + 1'b1;
      if (evt_result)       code_q  <= seen_code;
      if (evt_finish)       stat_q  <= fin_status;
    end
  end

  assign busy_o      = (state != S_IDLE);
  assign issue_o     = (state == S_ISSUE);
  assign issue_cmd_o = cmd_q;
  assign rst_req_o   = (state == S_RESET);
  assign done_o      = done_q;
  assign status_o    = stat_q;
  assign last_code_o = code_q;
  assign attempts_o  = tries_q;

endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
  parameter int MAX_TRIES   = 4,
  parameter int CMD_TMO_CYC = 64,
  parameter int RST_TMO_CYC = 32
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic issue_o,
  input logic rst_req_o,
  input logic rst_ack_i
);
  int unsigned n_issue;
  int unsigned wait_cnt;
  int unsigned rst_cnt;
  logic        in_wait;

  assign in_wait = busy_o && !issue_o && !rst_req_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_issue  <= 0;
      wait_cnt <= 0;
      rst_cnt  <= 0;
    end else begin
      if (start_i && !busy_o) n_issue <= 0;
      else if (issue_o)       n_issue <= n_issue + 1;
      wait_cnt <= in_wait ? wait_cnt + 1 : 0;
      rst_cnt  <= rst_req_o ? rst_cnt + 1 : 0;
    end
  end

  assert_issue_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |=> !issue_o);
  assert_start_issues_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> issue_o);
  assert_no_issue_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !issue_o);
  assert_reset_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && !rst_ack_i) |=> (rst_req_o || done_o));
  assert_attempt_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> (n_issue < MAX_TRIES));
  assert_cmd_watchdog_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (wait_cnt < CMD_TMO_CYC));
  assert_reset_watchdog_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (rst_cnt < RST_TMO_CYC));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind retry_sequencer rr_checker #(
  .MAX_TRIES  (MAX_TRIES),
  .CMD_TMO_CYC(CMD_TMO_CYC),
  .RST_TMO_CYC(RST_TMO_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .issue_o  (issue_o),
  .rst_req_o(rst_req_o),
  .rst_ack_i(rst_ack_i)
);

// File: tb/retry_sequencer_bench.sv
module retry_sequencer_bench;
  localparam int CMD_W = 8;
  localparam int MAXT  = 4;
  localparam int CTMO  = 40;
  localparam int RTMO  = 24;
  localparam int AW    = $clog2(MAXT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CMD_W-1:0] cmd_i = '0;
  logic busy_o, done_o, issue_o, rst_req_o;
  logic [2:0] status_o;
  logic [7:0] last_code_o;
  logic [AW-1:0] attempts_o;
  logic [CMD_W-1:0] issue_cmd_o;
  logic cmpl_i = 1'b0;
  logic [7:0] err_code_i = '0;
  logic rst_ack_i = 1'b0;

  always #4 clk = ~clk;

  retry_sequencer #(.CMD_W(CMD_W), .MAX_TRIES(MAXT), .CMD_TMO_CYC(CTMO), .RST_TMO_CYC(RTMO))
    u_retry_sequencer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
      .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
      .last_code_o(last_code_o), .attempts_o(attempts_o),
      .issue_o(issue_o), .issue_cmd_o(issue_cmd_o),
      .cmpl_i(cmpl_i), .err_code_i(err_code_i),
      .rst_req_o(rst_req_o), .rst_ack_i(rst_ack_i));

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Per-attempt executor script.
  logic [7:0] r_code [MAXT];
  bit         r_tmo  [MAXT];
  int         r_dly  [MAXT];
  bit         rst_hang;
  int         rst_dly;
  logic [CMD_W-1:0] cur_cmd;

  // Executor observations.
  int issues_seen, resets_seen, cmd_err;
  bit pend, prev_rreq;
  int cd, idx, rcnt;

  // Expected results.
  int exp_st, exp_att, exp_rst;
  logic [7:0] exp_code;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    cmpl_i    = 1'b0;
    rst_ack_i = 1'b0;
    if (issue_o) begin
      idx = issues_seen;
      issues_seen++;
      if (issue_cmd_o != cur_cmd) cmd_err++;
      pend = 1'b1;
      cd = (idx < MAXT) ? r_dly[idx] : 0;
    end else if (rst_req_o) begin
      pend = 1'b0;
    end else if (pend && idx < MAXT && !r_tmo[idx]) begin
      if (cd == 0) begin
        cmpl_i     = 1'b1;
        err_code_i = r_code[idx];
        pend       = 1'b0;
      end else cd--;
    end
    if (rst_req_o && !prev_rreq) begin
      resets_seen++;
      rcnt = 0;
    end
    if (rst_req_o) begin
      if (!rst_hang && rcnt == rst_dly) rst_ack_i = 1'b1;
      rcnt++;
    end
    prev_rreq = rst_req_o;
  end

  // Independent reference of the retry policy.
  function automatic void model();
    int cls;
    exp_rst = 0;
    exp_st = 0;
    exp_code = 8'h00;
    exp_att = 0;
    for (int i = 0; i < MAXT; i++) begin
      exp_att  = i + 1;
      exp_code = r_tmo[i] ? 8'hFF : r_code[i];
      cls = exp_code >> 4;
      if (!r_tmo[i] && (exp_code == 0 || cls == 3)) begin exp_st = 0; break; end
      else if (!r_tmo[i] && cls == 4) begin
        if (exp_att < MAXT) continue;
        exp_st = 2; break;
      end else if (r_tmo[i] || cls == 6) begin
        if (exp_att >= MAXT) begin exp_st = 2; break; end
        exp_rst++;
        if (rst_hang) begin exp_st = 4; break; end
        continue;
      end else if (cls == 1 || cls == 2 || cls == 9) begin exp_st = 1; break; end
      else begin exp_st = 3; break; end
    end
  endfunction

  function automatic string req_of(input int st);
    case (st)
      0: return "R3";
      1: return "R6";
      2: return "R8";
      3: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic run_case(input logic [CMD_W-1:0] c);
    int guard;
    cur_cmd = c;
    issues_seen = 0; resets_seen = 0; cmd_err = 0; pend = 1'b0;
    model();
    @(negedge clk); cmd_i = c; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    // R2: a start while busy must be ignored.
    @(negedge clk); cmd_i = ~c; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 2000) begin @(negedge clk); guard++; end
    check(done_o == 1'b1, "R11 done seen", int'(done_o), 1);
    check(int'(status_o) == exp_st, req_of(exp_st), int'(status_o), exp_st);
    check(last_code_o == exp_code, "R11 last code", int'(last_code_o), int'(exp_code));
    check(int'(attempts_o) == exp_att, "R11 attempts", int'(attempts_o), exp_att);
    check(issues_seen == exp_att, "R8 issue count", issues_seen, exp_att);
    check(resets_seen == exp_rst, "R5 reset count", resets_seen, exp_rst);
    check(cmd_err == 0, "R2 issued command", cmd_err, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R11 done pulse", int'(done_o), 0);
  endtask

  task automatic set_all(input logic [7:0] code);
    for (int i = 0; i < MAXT; i++) begin r_code[i] = code; r_tmo[i] = 1'b0; r_dly[i] = 1; end
    rst_hang = 1'b0; rst_dly = 2;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    set_all(8'h00);
    issues_seen = 0; resets_seen = 0; cmd_err = 0; prev_rreq = 1'b0; rcnt = 0;
    cur_cmd = '0;
    repeat (3) @(negedge clk);
    check(!busy_o && !issue_o && !rst_req_o && !done_o, "R1 idle outputs",
          {busy_o, issue_o, rst_req_o, done_o}, 0);
    check(status_o == 3'd0 && last_code_o == 8'h00 && attempts_o == '0, "R1 result regs",
          {status_o, last_code_o}, 0);
    rst_n = 1'b1;

    set_all(8'h00); run_case(8'h11);                                // R3
    set_all(8'h35); run_case(8'h22);                                // R3 recovered
    set_all(8'h00); r_code[0] = 8'h41; run_case(8'h33);             // R4
    set_all(8'h00); r_code[0] = 8'h60; run_case(8'h44);             // R5
    set_all(8'h40); run_case(8'h55);                                // R8 exhausted
    set_all(8'h64); run_case(8'h56);                                // R8 no fourth reset
    set_all(8'h12); run_case(8'h66);                                // R6
    set_all(8'h95); run_case(8'h67);                                // R6
    set_all(8'h05); run_case(8'h77);                                // R7 class 0 nonzero
    set_all(8'hE3); run_case(8'h78);                                // R7 high codes
    set_all(8'h00); r_tmo[0] = 1'b1; run_case(8'h88);               // R9
    set_all(8'h00); r_tmo[0] = 1'b1; rst_hang = 1'b1; run_case(8'h99); // R10
    set_all(8'h00); r_code[0] = 8'h64; rst_hang = 1'b1; run_case(8'h9A); // R10

    for (int n = 0; n < 250; n++) begin
      for (int i = 0; i < MAXT; i++) begin
        int sel = $urandom_range(0, 9);
        case (sel)
          0, 1, 2: r_code[i] = {4'h4, 4'($urandom_range(0, 15))};
          3, 4:    r_code[i] = {4'h6, 4'($urandom_range(0, 15))};
          5:       r_code[i] = {4'h3, 4'($urandom_range(0, 15))};
          6:       r_code[i] = 8'h00;
          default: r_code[i] = 8'($urandom_range(0, 255));
        endcase
        r_tmo[i] = ($urandom_range(0, 9) == 0);
        r_dly[i] = $urandom_range(0, 5);
      end
      rst_hang = ($urandom_range(0, 19) == 0);
      rst_dly  = $urandom_range(0, 6);
      run_case(8'($urandom_range(0, 255)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule